// File: doc/BRIEF.md
# Link-layer message transmit control and status register

This block is one byte-wide register on a simple microprocessor bus inside a DS3 framer. Software uses it to start a link-layer message transmitter, to watch whether that transmitter is busy, and to learn when a message has gone out. It turns a written 0-to-1 change of its start field into a single-cycle start pulse for the transmitter. It keeps a sticky completion flag that a read of the register clears. It drives an interrupt line when a completion is pending and the interrupt is enabled.

The transmitter sits outside this block and reports back through two inputs. `tx_busy` is a level that is high while a message is being sent. `tx_done` is a one-cycle pulse when a message has been sent. A framing-mode input gates every field, so the register is active only when C-bit parity framing is selected. With that mode off, the register reads as zero, ignores writes and completion pulses, does not clear on reads, and holds the interrupt low.

Top module: `lapd_tx_ctrl_reg`

## Requirements
- R1: After reset, a read of the register returns 0x00, and both `tx_start` and `irq` are low.
- R2: The register answers only at address 0x1F. A read at any other address returns 0x00. A write at any other address leaves the register contents unchanged.
- R3: A read at 0x1F returns its data combinationally in the same cycle as `bus_rd`. The layout is: bits 7..4 are 0, bit 3 is the stored start field, bit 2 is the live `tx_busy` input, bit 1 is the stored interrupt enable, and bit 0 is the completion status.
- R4: A write to 0x1F stores data bit 3 as the start field and data bit 1 as the interrupt enable. Other data bits have no effect.
- R5: A write with data bit 3 = 1 raises `tx_start` for exactly one cycle, in the cycle after the write. This happens only when the stored start field was 0 before the write and `tx_busy` is 0.
- R6: Writing 1 to the start field while it already holds 1 produces no pulse. A new pulse needs a write of 0 followed by a write of 1.
- R7: A start write made while `tx_busy` is 1 produces no pulse. The start field still stores the written value.
- R8: A `tx_done` pulse sets the completion status, and the status is visible from the next cycle. A read at 0x1F clears the status after returning it.
- R9: If `tx_done` and a read at 0x1F fall in the same cycle, the read returns the old status and the status is set afterwards.
- R10: `irq` is high exactly when the completion status and the interrupt enable are both 1 and C-bit parity mode is on.
- R11: While `cbit_mode` is 0, the register behaves as follows: reads return 0x00 and do not clear the status, writes and `tx_done` are ignored, no start pulse is issued, and `irq` is low. The stored state reappears when the mode returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cbit_mode | input | 1 | 1 when C-bit parity framing is selected |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| tx_busy | input | 1 | Transmitter is sending a message |
| tx_done | input | 1 | One-cycle pulse when a message has been sent |
| tx_start | output | 1 | One-cycle start request to the transmitter |
| irq | output | 1 | Completion interrupt |

## Verification
Read data has no register in its path, so the bench samples `bus_rdata` one nanosecond after it drives the strobe on the falling edge, before the rising edge that acts on the read. `tx_start` and the completion status each pass through one flop. The bench therefore samples them just after the rising edge that takes the write or the `tx_done` pulse. It then samples `tx_start` again one cycle later to confirm that the pulse has already fallen. `irq` is combinational from the status flop, so it is checked on the same cycle as the status. Sweeps cover every write byte, with both prior start values and both busy levels, and every non-matching address. Each sweep's expected values are computed from the requirement formulas.

// File: rtl/lapd_ctl_pkg.sv
// Package: field positions and reset values shared by the link-layer
// transmit control register and its checker.
package lapd_ctl_pkg;
    localparam int START_POS = 3;   // stored start request field
    localparam int BUSY_POS  = 2;   // live transmitter busy flag
    localparam int IEN_POS   = 1;   // completion interrupt enable
    localparam int STAT_POS  = 0;   // sticky completion status
    localparam int USED_BITS = 4;   // bits above this read as zero

    // Writable control fields held by the start controller.
    typedef struct packed {
        logic start;
        logic ien;
    } ctl_fields_t;

    localparam ctl_fields_t CTL_RESET = '{start: 1'b0, ien: 1'b0};
endpackage

// File: rtl/lapd_reg_decode.sv
// Module: lapd_reg_decode
// Matches the bus address against the register address and qualifies
// the read and write strobes with the framing mode.
// Assumes single-cycle strobes and that an access with the mode off
// must have no effect at all.
module lapd_reg_decode #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1F
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              cbit_mode,
    output logic              rd_hit,
    output logic              wr_hit
);
    logic addr_match;

    // Compare the address and gate both strobes with the mode.
    always_comb begin
        addr_match = (bus_addr == REG_ADDR);
        rd_hit     = bus_rd && addr_match && cbit_mode;
        wr_hit     = bus_wr && addr_match && cbit_mode;
    end
endmodule

// File: rtl/lapd_start_ctrl.sv
// Module: lapd_start_ctrl
// Holds the writable start and interrupt-enable fields. It issues a
// one-cycle start pulse when a write moves the start field from 0 to 1
// while the transmitter is idle.
// Assumes wr_hit is already qualified by address and mode.
module lapd_start_ctrl
    import lapd_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic        wr_start,
    input  logic        wr_ien,
    input  logic        tx_busy,
    output ctl_fields_t ctl_q,
    output logic        tx_start
);
    logic rise_req;

    // A start request exists only for a 0-to-1 write while idle.
    always_comb begin
        rise_req = wr_hit && wr_start && !ctl_q.start && !tx_busy;
    end

    // Store the control fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (wr_hit) begin
            ctl_q.start <= wr_start;
            ctl_q.ien   <= wr_ien;
        end
    end

    // Register the start pulse so it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_start <= 1'b0;
        end else begin
            tx_start <= rise_req;
        end
    end
endmodule

// File: rtl/lapd_done_status.sv
// Module: lapd_done_status
// Keeps the sticky completion flag and forms the interrupt output.
// A completion pulse wins over a clearing read in the same cycle.
// Assumes rd_hit is already qualified by address and mode.
module lapd_done_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cbit_mode,
    input  logic tx_done,
    input  logic rd_hit,
    input  logic ien,
    output logic stat_q,
    output logic irq
);
    logic set_evt;

    // A completion counts only while the mode is on.
    always_comb begin
        set_evt = tx_done && cbit_mode;
    end

    // Set on completion, otherwise clear on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (set_evt) begin
            stat_q <= 1'b1;
        end else if (rd_hit) begin
            stat_q <= 1'b0;
        end
    end

    // Interrupt is the enabled status, held low with the mode off.
    always_comb begin
        irq = stat_q && ien && cbit_mode;
    end
endmodule

// File: rtl/lapd_tx_ctrl_reg.sv
// Module: lapd_tx_ctrl_reg
// Control, status and interrupt register for a link-layer message
// transmitter. It decodes bus accesses, forms the start pulse, keeps
// the completion flag and returns the read byte.
// Assumes one access per strobe cycle and a transmitter that reports
// busy as a level and completion as a one-cycle pulse.
module lapd_tx_ctrl_reg
    import lapd_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cbit_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_busy,
    input  logic              tx_done,
    output logic              tx_start,
    output logic              irq
);
    logic        rd_hit;
    logic        wr_hit;
    logic        stat_q;
    ctl_fields_t ctl_q;

    lapd_reg_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_decode (
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .cbit_mode (cbit_mode),
        .rd_hit    (rd_hit),
        .wr_hit    (wr_hit)
    );

    lapd_start_ctrl u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .wr_start (bus_wdata[START_POS]),
        .wr_ien   (bus_wdata[IEN_POS]),
        .tx_busy  (tx_busy),
        .ctl_q    (ctl_q),
        .tx_start (tx_start)
    );

    lapd_done_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cbit_mode (cbit_mode),
        .tx_done   (tx_done),
        .rd_hit    (rd_hit),
        .ien       (ctl_q.ien),
        .stat_q    (stat_q),
        .irq       (irq)
    );

    // Assemble the read byte; zero when the access does not hit.
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            bus_rdata[START_POS] = ctl_q.start;
            bus_rdata[BUSY_POS]  = tx_busy;
            bus_rdata[IEN_POS]   = ctl_q.ien;
            bus_rdata[STAT_POS]  = stat_q;
        end
    end
endmodule

// File: rtl/lapd_tx_ctrl_reg_chk.sv
// Module: lapd_tx_ctrl_reg_chk
// Assertion checker attached to lapd_tx_ctrl_reg by the bind below.
// It relates the bus, the transmitter handshake and the status flag
// over time.
module lapd_tx_ctrl_reg_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cbit_mode,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_busy,
    input logic              tx_done,
    input logic              tx_start,
    input logic              irq,
    input logic              stat_q
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start); // R5

    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(bus_wr && bus_addr == REG_ADDR && bus_wdata[3] && cbit_mode)); // R5

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !$past(tx_busy)); // R7

    AST_DONE_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && cbit_mode) |=> stat_q); // R9

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> bus_rdata[DATA_W-1:4] == '0); // R3

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cbit_mode |-> !irq); // R11

    AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_q); // R10

    AST_MODE_OFF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !cbit_mode |-> bus_rdata == '0); // R11
endmodule

bind lapd_tx_ctrl_reg lapd_tx_ctrl_reg_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cbit_mode (cbit_mode),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_busy   (tx_busy),
    .tx_done   (tx_done),
    .tx_start  (tx_start),
    .irq       (irq),
    .stat_q    (stat_q)
);

// File: tb/lapd_tx_ctrl_reg_tb_top.sv
// Bench: sweeps write data, prior start value, busy level and address,
// then walks the completion status, interrupt and mode gating.
`timescale 1ns/1ps
module lapd_tx_ctrl_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cbit_mode = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tx_busy = 1'b0;
    logic       tx_done = 1'b0;
    logic       tx_start;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [7:0] RA = 8'h1F;

    always #2.5 clk = ~clk;

    lapd_tx_ctrl_reg dut_i (
        .clk (clk), .rst_n (rst_n), .cbit_mode (cbit_mode),
        .bus_addr (bus_addr), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .tx_busy (tx_busy), .tx_done (tx_done),
        .tx_start (tx_start), .irq (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Idle the bus for one cycle.
    task automatic idle();
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; tx_done = 0;
        @(posedge clk); #1;
    endtask

    // Write; returns tx_start in the cycle after and one cycle later.
    task automatic wr(input logic [7:0] a, input logic [7:0] d,
                      output logic p1, output logic p2);
        @(negedge clk);
        bus_rd = 0; tx_done = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1; p1 = tx_start;
        @(negedge clk); bus_wr = 0;
        @(posedge clk); #1; p2 = tx_start;
    endtask

    // Read; data sampled before the acting edge. Optional done pulse.
    task automatic rd(input logic [7:0] a, input logic done, output logic [7:0] d);
        @(negedge clk);
        bus_wr = 0; bus_rd = 1; bus_addr = a; tx_done = done;
        #1; d = bus_rdata;
        @(posedge clk); #1;
        @(negedge clk); bus_rd = 0; tx_done = 0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        tx_done = 1;
        @(posedge clk); #1;
        @(negedge clk); tx_done = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic p1, p2;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 start", tx_start, 0);
        chk("R1 irq", irq, 0);
        rd(RA, 0, r); chk("R1 rdata", r, 0);

        // R3 R4 R5 R6 R7: sweep prior start, busy and every write byte
        for (int prev = 0; prev < 2; prev++) begin
            for (int busy = 0; busy < 2; busy++) begin
                for (int w = 0; w < 256; w++) begin
                    tx_busy = 0;
                    wr(RA, 8'(prev << 3), p1, p2);
                    @(negedge clk); tx_busy = logic'(busy);
                    wr(RA, 8'(w), p1, p2);
                    chk("R5/R6/R7 start pulse", p1,
                        int'(w[3] && prev == 0 && busy == 0));
                    chk("R5 pulse width", p2, 0);
                    rd(RA, 0, r);
                    chk("R3/R4 readback", r, (w & 8'h0A) | (busy << 2));
                end
            end
        end
        tx_busy = 0;

        // R2: every other address reads zero and leaves contents intact
        wr(RA, 8'h02, p1, p2);
        for (int a = 0; a < 256; a++) begin
            if (a != int'(RA)) begin
                wr(8'(a), 8'hFF, p1, p2);
                chk("R2 foreign write no pulse", p1, 0);
                rd(8'(a), 0, r); chk("R2 foreign read", r, 0);
                rd(RA, 0, r);    chk("R2 contents kept", r, 8'h02);
            end
        end

        // R8 R10: completion status and interrupt for both enables
        for (int en = 0; en < 2; en++) begin
            wr(RA, 8'(en << 1), p1, p2);
            chk("R10 irq idle", irq, 0);
            done_pulse();
            chk("R10 irq after done", irq, en);
            rd(RA, 0, r); chk("R8 status set", r, (en << 1) | 1);
            chk("R10 irq cleared by read", irq, 0);
            rd(RA, 0, r); chk("R8 status cleared", r, en << 1);
        end

        // R9: completion and read in the same cycle
        rd(RA, 1, r); chk("R9 read returns old", r, 8'h02);
        chk("R9 irq", irq, 1);
        rd(RA, 0, r); chk("R9 status kept", r, 8'h03);

        // R11: mode off gates everything
        done_pulse();
        @(negedge clk); cbit_mode = 0;
        @(posedge clk); #1;
        chk("R11 irq low", irq, 0);
        rd(RA, 0, r); chk("R11 read zero", r, 0);
        wr(RA, 8'h08, p1, p2); chk("R11 no start", p1, 0);
        @(negedge clk); cbit_mode = 1;
        @(posedge clk); #1;
        chk("R11 irq back", irq, 1);
        rd(RA, 0, r); chk("R11 state kept", r, 8'h03);
        @(negedge clk); cbit_mode = 0;
        done_pulse();
        @(negedge clk); cbit_mode = 1;
        @(posedge clk); #1;
        rd(RA, 0, r); chk("R11 done ignored", r, 8'h02);
        idle();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule